// File: doc/BRIEF.md
# Lookahead Slew-Limited Envelope Generator

This block takes a stream of unsigned envelope magnitudes, at most one per clock, and produces a slowed copy that a supply modulator with a limited slope can follow. The slowed envelope never drops below the input envelope it is paired with. Its fall per sample is capped at a run-time step, and its rise is kept within the same step by looking ahead. The block holds a window of N+1 samples, so each output belongs to the sample accepted N samples earlier. That earlier sample is also presented on a second output, which keeps the slowed envelope and the raw envelope lined up for downstream use.

For the sample at the old end of the window, the block computes a bound. Each window entry at distance i has i times the step subtracted from it, the results are clamped at zero, and the largest of them is the bound. A registered compare-and-select tree reduces these terms. A final recursive stage then takes the larger of the bound and the previous output lowered by one step. Samples use full scale 2^W−1 to stand for 1.0. The step input is held steady from reset onward.

Top module: `slew_env_gen`

## Requirements
- R1: On a clock edge with rst_n low, out_valid, out_env and out_ref all become zero.
- R2: Let L = clog2(N+1). After reset, out_valid first pulses on the (L+2)-th clock edge after the edge that accepts the (N+1)-th sample. After that, exactly one out_valid pulse follows each further accepted sample, in acceptance order.
- R3: Output number n (counting from 0) presents on out_ref the input sample E(n), which is the n-th accepted sample.
- R4: The lookahead bound for output n is y(n) = max over i = 0..N of E(n+i) − i·step, where each term below zero counts as zero. All values are unsigned W-bit.
- R5: out_env for output n equals max(y(n), Es(n−1) − step), where the lowered value is floored at zero and Es(−1) = 0 after reset.
- R6: On every valid output, out_env ≥ out_ref.
- R7: When N·step ≥ 2^W−1, two consecutive valid outputs differ by at most step, in either direction.
- R8: out_env keeps its value in every cycle where out_valid is low. Cycles with in_valid low do not change the sequence of valid outputs.
- R9: With step = 0 the valid outputs never decrease. With step ≥ 2^W−1, out_env equals out_ref on every valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept in_env on this edge |
| in_env | input | W | Envelope magnitude sample |
| step | input | W | Largest change per sample; held steady after reset |
| out_valid | output | 1 | out_env and out_ref carry a new pair |
| out_env | output | W | Slew-limited upper-bound envelope |
| out_ref | output | W | Input envelope delayed to match out_env |

## Verification
The lookahead bound and the recursive decay compete in every output cycle. The hard cases are when both give the same value, or when they hand over from one to the other while the input rises and falls sharply. Full-scale steps, isolated spikes and long zero runs are mixed with random streams that have random idle gaps. For each case the bench computes both equations on its own and compares out_env with the larger of the two. On each valid output it also checks the bound against out_ref and the change from the previous output against step.

// File: rtl/slew_env_pkg.sv
// Shared defaults and constant helpers for the slew-limited envelope generator.
package slew_env_pkg;

    localparam int DEF_SAMPLE_W  = 14;
    localparam int DEF_LOOKAHEAD = 10;

    // Number of pairwise select levels needed to reduce the given leaf count to one.
    function automatic int tree_levels(input int leaves);
        int lv;
        int span;
        lv   = 0;
        span = 1;
        while (span < leaves) begin
            span = span * 2;
            lv   = lv + 1;
        end
        return lv;
    endfunction

endpackage

// File: rtl/slew_env_window.sv
// Lookahead window and ramp-term stage.
// Holds the last N+1 accepted samples. Slot 0 is the oldest sample E(n) and
// slot N is the newest, E(n+N). Once N+1 samples have arrived, the stage
// registers one term per slot: the sample minus (slot index * step), clamped
// at zero. It also registers the oldest sample as the aligned reference.
// Assumes step is steady while samples stream.
module slew_env_window
    import slew_env_pkg::*;
#(
    parameter int W = DEF_SAMPLE_W,
    parameter int N = DEF_LOOKAHEAD
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_env,
    input  logic [W-1:0] step,
    output logic         term_v,
    output logic [W-1:0] term_q [0:N],
    output logic [W-1:0] ref_q
);

    localparam int CNT_W  = $clog2(N + 1) + 1;
    localparam int PROD_W = W + $clog2(N + 1) + 1;

    logic [W-1:0]      win    [0:N];
    logic [W-1:0]      term_d [0:N];
    logic [PROD_W-1:0] ramp   [0:N];
    logic [CNT_W-1:0]  fill_cnt;
    logic              full_v;

    // Shift a newly accepted sample into the newest slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k <= N; k++) win[k] <= '0;
        end else if (in_valid) begin
            for (int k = 0; k < N; k++) win[k] <= win[k + 1];
            win[N] <= in_env;
        end
    end

    // Count accepted samples until the window is full, then flag each complete window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            full_v   <= 1'b0;
        end else begin
            full_v <= in_valid && (fill_cnt == CNT_W'(N));
            if (in_valid && (fill_cnt != CNT_W'(N))) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // Subtract the ramp from each slot, clamping results below zero.
    always_comb begin
        for (int i = 0; i <= N; i++) begin
            ramp[i]   = PROD_W'(i) * PROD_W'(step);
            term_d[i] = (PROD_W'(win[i]) > ramp[i]) ? W'(PROD_W'(win[i]) - ramp[i]) : '0;
        end
    end

    // Register the terms and the aligned reference sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_v <= 1'b0;
            ref_q  <= '0;
            for (int i = 0; i <= N; i++) term_q[i] <= '0;
        end else begin
            term_v <= full_v;
            ref_q  <= win[0];
            term_q <= term_d;
        end
    end

endmodule

// File: rtl/slew_env_maxtree.sv
// Registered compare-and-select tree.
// Reduces LEAVES unsigned values to their maximum, one register level per
// pairing step. Leaves are padded with zeros up to a power of two; a zero
// never wins over an unsigned value. A valid flag and a tag word travel
// alongside the data with the same latency. Assumes LEAVES >= 2.
module slew_env_maxtree
    import slew_env_pkg::*;
#(
    parameter int W      = DEF_SAMPLE_W,
    parameter int LEAVES = DEF_LOOKAHEAD + 1
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] leaves [0:LEAVES-1],
    input  logic [W-1:0] in_tag,
    output logic         out_v,
    output logic [W-1:0] out_max,
    output logic [W-1:0] out_tag
);

    localparam int LVLS = tree_levels(LEAVES);
    localparam int PAD  = 1 << LVLS;

    logic [W-1:0] base [0:PAD-1];

    for (genvar j = 0; j < PAD; j++) begin : g_pad
        if (j < LEAVES) begin : g_leaf
            assign base[j] = leaves[j];
        end else begin : g_zero
            assign base[j] = '0;
        end
    end

    for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
        localparam int CNT = PAD >> (lv + 1);
        logic [W-1:0] src [0:2*CNT-1];
        logic [W-1:0] q   [0:CNT-1];
        logic         v_src;
        logic         v_q;
        logic [W-1:0] tag_src;
        logic [W-1:0] tag_q;

        if (lv == 0) begin : g_src
            assign v_src   = in_v;
            assign tag_src = in_tag;
            for (genvar j = 0; j < 2 * CNT; j++) begin : g_in
                assign src[j] = base[j];
            end
        end else begin : g_src
            assign v_src   = g_lvl[lv-1].v_q;
            assign tag_src = g_lvl[lv-1].tag_q;
            for (genvar j = 0; j < 2 * CNT; j++) begin : g_in
                assign src[j] = g_lvl[lv-1].q[j];
            end
        end

        // Pass the larger of each pair to the next level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else begin
                v_q <= v_src;
            end
            tag_q <= tag_src;
            for (int j = 0; j < CNT; j++) begin
                q[j] <= (src[2*j] >= src[2*j+1]) ? src[2*j] : src[2*j+1];
            end
        end
    end

    assign out_v   = g_lvl[LVLS-1].v_q;
    assign out_max = g_lvl[LVLS-1].q[0];
    assign out_tag = g_lvl[LVLS-1].tag_q;

endmodule

// File: rtl/slew_env_decay.sv
// Recursive fall limiter and output register.
// On each valid bound, it outputs the larger of the bound and the previous
// output lowered by step, floored at zero. The output register is also the
// recursion state, so it holds its value between valid bounds.
module slew_env_decay
    import slew_env_pkg::*;
#(
    parameter int W = DEF_SAMPLE_W
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         y_v,
    input  logic [W-1:0] y,
    input  logic [W-1:0] ref_in,
    input  logic [W-1:0] step,
    output logic         out_valid,
    output logic [W-1:0] out_env,
    output logic [W-1:0] out_ref
);

    logic [W-1:0] floor_val;
    logic [W-1:0] next_env;

    // Lower the previous output by one step and pick the larger candidate.
    always_comb begin
        floor_val = (out_env > step) ? (out_env - step) : '0;
        next_env  = (y > floor_val) ? y : floor_val;
    end

    // Update the output pair on each valid bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_env   <= '0;
            out_ref   <= '0;
        end else begin
            out_valid <= y_v;
            if (y_v) begin
                out_env <= next_env;
                out_ref <= ref_in;
            end
        end
    end

endmodule

// File: rtl/slew_env_gen.sv
// Top level of the lookahead slew-limited envelope generator.
// Path: window and ramp terms (1 stage), max tree (clog2(N+1) stages),
// decay (1 stage). Requires N >= 1 and step held steady after reset.
module slew_env_gen
    import slew_env_pkg::*;
#(
    parameter int W = DEF_SAMPLE_W,
    parameter int N = DEF_LOOKAHEAD
)
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_env,
    input  logic [W-1:0] step,
    output logic         out_valid,
    output logic [W-1:0] out_env,
    output logic [W-1:0] out_ref
);

    logic         term_v;
    logic [W-1:0] term_q [0:N];
    logic [W-1:0] ref_q;
    logic         y_v;
    logic [W-1:0] y_max;
    logic [W-1:0] y_ref;

    slew_env_window #(.W(W), .N(N)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_env   (in_env),
        .step     (step),
        .term_v   (term_v),
        .term_q   (term_q),
        .ref_q    (ref_q)
    );

    slew_env_maxtree #(.W(W), .LEAVES(N + 1)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (term_v),
        .leaves  (term_q),
        .in_tag  (ref_q),
        .out_v   (y_v),
        .out_max (y_max),
        .out_tag (y_ref)
    );

    slew_env_decay #(.W(W)) u_decay (
        .clk       (clk),
        .rst_n     (rst_n),
        .y_v       (y_v),
        .y         (y_max),
        .ref_in    (y_ref),
        .step      (step),
        .out_valid (out_valid),
        .out_env   (out_env),
        .out_ref   (out_ref)
    );

endmodule

// File: rtl/slew_env_gen_chk.sv
// Property checker for slew_env_gen, attached by bind at the end of this file.
// Tracks accepted samples and the previous valid output at the ports only.
module slew_env_gen_chk #(
    parameter int W = 14,
    parameter int N = 10
)
(
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] step,
    input logic         out_valid,
    input logic [W-1:0] out_env,
    input logic [W-1:0] out_ref
);

    localparam int SEEN_W = $clog2(N + 2) + 1;

    logic [SEEN_W-1:0] seen;
    logic              have_prev;
    logic [W-1:0]      last_es;
    logic [31:0]       span;
    logic              slew_ok;

    assign span    = 32'(step) * 32'(N);
    assign slew_ok = (span >= 32'((1 << W) - 1));

    // Count accepted samples (saturating) and remember the last valid output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= '0;
            have_prev <= 1'b0;
            last_es   <= '0;
        end else begin
            if (in_valid && (seen != SEEN_W'(N + 1))) seen <= seen + 1'b1;
            if (out_valid) begin
                have_prev <= 1'b1;
                last_es   <= out_env;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_env == '0 && out_ref == '0));

    assert_window_filled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen == SEEN_W'(N + 1)));

    assert_upper_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_env >= out_ref));

    assert_rise_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_prev && slew_ok) |-> ({1'b0, out_env} <= {1'b0, last_es} + {1'b0, step}));

    assert_fall_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && have_prev && slew_ok) |-> ({1'b0, out_env} + {1'b0, step} >= {1'b0, last_es}));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> $stable(out_env));

endmodule

bind slew_env_gen slew_env_gen_chk #(.W(W), .N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .step      (step),
    .out_valid (out_valid),
    .out_env   (out_env),
    .out_ref   (out_ref)
);

// File: tb/slew_env_gen_tb.sv
// Self-checking bench for slew_env_gen: directed and seeded random streams
// compared against a model of the bound and decay equations.
module slew_env_gen_tb;

    localparam int W   = 14;
    localparam int N   = 10;
    localparam int FS  = (1 << W) - 1;
    localparam int LAT = $clog2(N + 1) + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_env = '0;
    logic [W-1:0] step = '0;
    logic         out_valid;
    logic [W-1:0] out_env;
    logic [W-1:0] out_ref;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    int smp    [0:511];
    int exp_es [0:511];

    always #5 clk = ~clk;

    slew_env_gen #(.W(W), .N(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_env    (in_env),
        .step      (step),
        .out_valid (out_valid),
        .out_env   (out_env),
        .out_ref   (out_ref)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model of the lookahead bound and the recursive decay.
    task automatic build_model(input int stp, input int len);
        int prev;
        prev = 0;
        for (int n = 0; n + N < len; n++) begin
            int y;
            int d;
            y = 0;
            for (int i = 0; i <= N; i++) begin
                int t;
                t = smp[n + i] - i * stp;
                if (t < 0) t = 0;
                if (t > y) y = t;
            end
            d = prev - stp;
            if (d < 0) d = 0;
            exp_es[n] = (y > d) ? y : d;
            prev = exp_es[n];
        end
    endtask

    task automatic fill_random(input int len, input int maxv);
        for (int k = 0; k < len; k++) begin
            if ($urandom_range(9) == 0) smp[k] = FS;
            else if ($urandom_range(7) == 0) smp[k] = 0;
            else smp[k] = int'($urandom_range(maxv));
        end
    endtask

    task automatic run_case(input int stp, input int len, input int gap_pct, input bit lat_chk);
        int idx;
        int oi;
        int cyc;
        int drive_cyc;
        int first_cyc;
        int idle;
        int prev_es;
        bit have_prev;
        int last_out;
        bit slew_ok;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        step     = W'(stp);
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        chk(out_env == '0, "R1 out_env in reset", int'(out_env), 0);
        chk(out_ref == '0, "R1 out_ref in reset", int'(out_ref), 0);
        rst_n = 1'b1;
        build_model(stp, len);
        slew_ok   = (N * stp >= FS);
        idx       = 0;
        oi        = 0;
        cyc       = 0;
        drive_cyc = -1;
        first_cyc = -1;
        idle      = 0;
        prev_es   = 0;
        have_prev = 1'b0;
        last_out  = int'(out_env);
        while (idle < LAT + 6) begin
            @(negedge clk);
            cyc++;
            if (out_valid) begin
                if (first_cyc < 0) first_cyc = cyc;
                if (oi < len - N) begin
                    chk(int'(out_env) == exp_es[oi], "R4/R5 slowed envelope", int'(out_env), exp_es[oi]);
                    chk(int'(out_ref) == smp[oi], "R3 aligned reference", int'(out_ref), smp[oi]);
                    chk(out_env >= out_ref, "R6 upper bound", int'(out_env), int'(out_ref));
                    if (have_prev && slew_ok) begin
                        chk((int'(out_env) <= prev_es + stp) && (int'(out_env) + stp >= prev_es),
                            "R7 change per sample", int'(out_env), prev_es);
                    end
                    if (have_prev && stp == 0)
                        chk(int'(out_env) >= prev_es, "R9 non-decreasing at zero step", int'(out_env), prev_es);
                    if (stp >= FS)
                        chk(out_env == out_ref, "R9 full-scale step tracks input", int'(out_env), int'(out_ref));
                end else begin
                    chk(1'b0, "R2 extra output", oi, len - N - 1);
                end
                prev_es   = int'(out_env);
                have_prev = 1'b1;
                oi++;
            end else begin
                chk(int'(out_env) == last_out, "R8 hold while not valid", int'(out_env), last_out);
            end
            last_out = int'(out_env);
            if (idx < len && int'($urandom_range(99)) >= gap_pct) begin
                in_valid = 1'b1;
                in_env   = W'(smp[idx]);
                if (idx == N) drive_cyc = cyc;
                idx++;
            end else begin
                in_valid = 1'b0;
                if (idx >= len) idle++;
            end
        end
        chk(oi == len - N, "R2 output count", oi, len - N);
        if (lat_chk)
            chk(first_cyc == drive_cyc + LAT + 1, "R2 first output cycle", first_cyc, drive_cyc + LAT + 1);
    endtask

    initial begin
        int len;
        void'($urandom(32'd20240611));

        // Directed: full-scale step, drop, plateau, isolated spike.
        len = 0;
        for (int k = 0; k < 15; k++) smp[len++] = 0;
        for (int k = 0; k < 20; k++) smp[len++] = FS;
        for (int k = 0; k < 15; k++) smp[len++] = 0;
        for (int k = 0; k < 5; k++)  smp[len++] = 8000;
        smp[len++] = 12000;
        for (int k = 0; k < 15; k++) smp[len++] = 0;
        run_case(1639, len, 0, 1'b1);

        // Random full-range stream with idle gaps.
        fill_random(300, FS);
        run_case(2000, 300, 30, 1'b0);

        // Low-amplitude stream with full-scale bursts, the smallest slew-safe step, no gaps.
        fill_random(300, 3000);
        run_case(1639, 300, 0, 1'b1);

        // Zero step: output only rises.
        fill_random(120, FS);
        run_case(0, 120, 20, 1'b0);

        // Full-scale step: output equals the aligned input.
        fill_random(100, FS);
        run_case(FS, 100, 10, 1'b0);

        // Large step with heavy gaps.
        fill_random(200, FS);
        run_case(5000, 200, 50, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule